// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns one 32-bit virtual address into a 34-bit physical address. It walks a two-level radix page table whose top level is found through a root page-number input. It accepts one translation at a time. It fetches 4-byte page-table entries over a memory port that has a single outstanding request. It checks every entry it fetches, and it ends with one of three results: a physical address, a page fault, or an access fault. A caller supplies the access kind (load, store or fetch), the privilege level, and two permission modifiers. The first modifier lets supervisor code touch user pages. The second makes execute-only pages readable.

The walk is built as a state machine with six named states:
- `ST_IDLE` waits for a request.
- `ST_RD_ISSUE` sends an entry read.
- `ST_RD_WAIT` evaluates the returned entry.
- `ST_CAS_ISSUE` sends an atomic compare-and-write that sets the accessed and dirty flags.
- `ST_CAS_WAIT` checks the old value returned by that write.
- `ST_DONE` presents the result for one cycle.

The state machine has these transitions:
- accept: `ST_IDLE` to `ST_RD_ISSUE`
- issue: to the matching wait state
- descend: `ST_RD_WAIT` to `ST_RD_ISSUE`, one level down
- update: `ST_RD_WAIT` to `ST_CAS_ISSUE`
- retry: `ST_CAS_WAIT` to `ST_RD_ISSUE`, when the compare mismatches
- finish: any wait state to `ST_DONE`
- release: `ST_DONE` to `ST_IDLE`

The memory port reports a protection fault on each response. A compare-and-write request carries the value to compare and the value to write. The memory returns the old word, and it writes only when that word equals the compare value. When the flag-update enable is low, a missing accessed or dirty flag is reported as a page fault instead of being repaired.

Top module: `pgwalk_top`

## Requirements
- R1: `req_ready` is high only in idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` then stays low until the cycle after the single-cycle `rsp_valid` pulse.
- R2: The first entry read goes to byte address {root_ppn, vaddr[31:22], 2'b00}. A read at the lower level goes to {entry[31:10], vaddr[21:12], 2'b00}. Each memory request is high for exactly one cycle, and a request that needs 2 memory accesses produces its result 5 cycles after acceptance.
- R3: A fault flagged on an entry read ends the walk with an access fault. The cause is 1 for a fetch, 5 for a load and 7 for a store.
- R4: An entry with V (bit 0) clear, or with R (bit 1) clear and W (bit 2) set, ends the walk with a page fault. The cause is 12 for a fetch, 13 for a load and 15 for a store. In the access kind encoding, 0 is load, 1 is store and 2 is fetch.
- R5: A valid entry with R and X (bit 3) both clear points to the next level. If it is found at the lower level, the walk ends with a page fault.
- R6: A leaf must grant the access. A load needs R, or X while `req_mxr` is set. A store needs W. A fetch needs X. Otherwise the result is a page fault.
- R7: With `req_priv_s` low (user), a leaf needs U (bit 4). With `req_priv_s` high (supervisor), a leaf with U set allows a load or store only when `req_sum` is set, and never allows a fetch. Any violation is a page fault.
- R8: A leaf at the top level whose entry bits 19:10 are not zero is a misaligned superpage and gives a page fault.
- R9: With `ad_update_en` low, a leaf that passes every other check gives a page fault if A (bit 6) is clear, or if the access is a store and D (bit 7) is clear. No write is issued in that case.
- R10: With `ad_update_en` high in that same case, a compare-and-write is issued to the entry address. It compares against the fetched entry and writes that entry with A set, and with D also set for a store. Success follows when the returned old value matches.
- R11: If the compare-and-write returns a value that differs from the fetched entry, the walk reads the same entry address again. A fault on the compare-and-write gives an access fault.
- R12: On success, bits 11:0 of the physical address equal bits 11:0 of the virtual address. A top-level leaf gives {entry[31:20], vaddr[21:12], vaddr[11:0]}. A lower-level leaf gives {entry[31:10], vaddr[11:0]}. `rsp_cause` is 0 on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_priv_s | input | 1 | 1 = supervisor, 0 = user |
| req_sum | input | 1 | Supervisor may load/store user pages |
| req_mxr | input | 1 | Executable pages are readable |
| ad_update_en | input | 1 | Repair A/D flags in memory instead of faulting |
| root_ppn | input | 22 | Page number of the top-level table |
| mem_req_valid | output | 1 | Memory request, one-cycle pulse |
| mem_req_cas | output | 1 | 1 = compare-and-write, 0 = read |
| mem_req_addr | output | 34 | Byte address of the entry |
| mem_req_cmp | output | 32 | Compare value for compare-and-write |
| mem_req_wdata | output | 32 | Write value for compare-and-write |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_rdata | input | 32 | Entry read, or old value for compare-and-write |
| mem_rsp_fault | input | 1 | Protection fault on this access |
| rsp_valid | output | 1 | Result pulse |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_cause | output | 4 | Fault cause, 0 on success |
| rsp_paddr | output | 34 | Physical address, valid when rsp_ok |

## Verification
Every memory access costs two cycles: one in an issue state and one in a wait state. The result therefore appears 2N+1 rising edges after the request is driven, where N is the number of memory accesses. That gives 3 for a superpage, 5 for a two-level walk or a leaf with an update, and 9 when a compare mismatch forces a retry. The bench counts edges from the accepting edge and samples on the falling edge, where `rsp_valid` is stable. It compares that count with 2N+1 for every scenario. The bench's memory model logs each request. The model answers on the falling edge one cycle after it sees a request, so each response lands in the cycle the walker is waiting for it. The bench checks entry addresses, the absence of writes and the contents of memory after an update directly against that log and that memory.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    localparam int VA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int VPN_W     = 10;
    localparam int PPN_W     = 22;
    localparam int PPN0_W    = 10;
    localparam int PPN1_W    = PPN_W - PPN0_W;
    localparam int PA_W      = PPN_W + OFF_W;
    localparam int PTE_W     = 32;
    localparam int PTE_LOG   = 2;
    localparam int FLAG_W    = 10;
    localparam int CAUSE_W   = 4;

    localparam int B_V = 0;
    localparam int B_R = 1;
    localparam int B_W = 2;
    localparam int B_X = 3;
    localparam int B_U = 4;
    localparam int B_A = 6;
    localparam int B_D = 7;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_CAS_ISSUE,
        ST_CAS_WAIT,
        ST_DONE
    } state_e;

    typedef enum logic [1:0] {
        EV_DESCEND,
        EV_PAGE_FAULT,
        EV_LEAF_OK,
        EV_NEED_AD
    } eval_e;

    function automatic logic [CAUSE_W-1:0] fault_cause(acc_e acc, logic page);
        logic [CAUSE_W-1:0] c;
        unique case (acc)
            ACC_FETCH: c = page ? 4'd12 : 4'd1;
            ACC_STORE: c = page ? 4'd15 : 4'd7;
            default:   c = page ? 4'd13 : 4'd5;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pgwalk_pte_eval.sv
module pgwalk_pte_eval
    import pgwalk_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  logic             lvl_top,
    input  acc_e             acc,
    input  logic             priv_s,
    input  logic             sum,
    input  logic             mxr,
    output eval_e            verdict,
    output logic [PTE_W-1:0] pte_upd
);

    logic v, r, w, x, u, a, d;
    logic kind_ok, priv_ok, misaligned;

    assign v = pte[B_V];
    assign r = pte[B_R];
    assign w = pte[B_W];
    assign x = pte[B_X];
    assign u = pte[B_U];
    assign a = pte[B_A];
    assign d = pte[B_D];

    assign misaligned = lvl_top && (pte[FLAG_W +: PPN0_W] != '0);

    always_comb begin
        unique case (acc)
            ACC_STORE: kind_ok = w;
            ACC_FETCH: kind_ok = x;
            default:   kind_ok = r || (x && mxr);
        endcase
    end

    always_comb begin
        if (!priv_s) begin
            priv_ok = u;
        end else if (u) begin
            priv_ok = (acc != ACC_FETCH) && sum;
        end else begin
            priv_ok = 1'b1;
        end
    end

    always_comb begin
        if (!v || (!r && w)) begin
            verdict = EV_PAGE_FAULT;
        end else if (!r && !x) begin
            verdict = lvl_top ? EV_DESCEND : EV_PAGE_FAULT;
        end else if (!kind_ok || !priv_ok || misaligned) begin
            verdict = EV_PAGE_FAULT;
        end else if (!a || ((acc == ACC_STORE) && !d)) begin
            verdict = EV_NEED_AD;
        end else begin
            verdict = EV_LEAF_OK;
        end
    end

    always_comb begin
        pte_upd      = pte;
        pte_upd[B_A] = 1'b1;
        if (acc == ACC_STORE) begin
            pte_upd[B_D] = 1'b1;
        end
    end

endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr
    import pgwalk_pkg::*;
(
    input  logic [PPN_W-1:0] base_ppn,
    input  logic             lvl_top,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PTE_W-1:0] leaf,
    output logic [PA_W-1:0]  pte_addr,
    output logic [PA_W-1:0]  paddr
);

    localparam int VPN0_LSB = OFF_W;
    localparam int VPN1_LSB = OFF_W + VPN_W;
    localparam int IDX_PAD  = OFF_W - VPN_W - PTE_LOG;

    logic [VPN_W-1:0] vpn_sel;

    assign vpn_sel  = lvl_top ? vaddr[VPN1_LSB +: VPN_W] : vaddr[VPN0_LSB +: VPN_W];
    assign pte_addr = {base_ppn, {IDX_PAD{1'b0}}, vpn_sel, {PTE_LOG{1'b0}}};

    always_comb begin
        if (lvl_top) begin
            paddr = {leaf[FLAG_W + PPN0_W +: PPN1_W], vaddr[VPN0_LSB +: VPN_W], vaddr[OFF_W-1:0]};
        end else begin
            paddr = {leaf[FLAG_W +: PPN_W], vaddr[OFF_W-1:0]};
        end
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_acc,
    input  logic               req_priv_s,
    input  logic               req_sum,
    input  logic               req_mxr,
    input  logic               ad_update_en,
    input  logic [PPN_W-1:0]   root_ppn,
    output logic               mem_req_valid,
    output logic               mem_req_cas,
    output logic [PA_W-1:0]    mem_req_addr,
    output logic [PTE_W-1:0]   mem_req_cmp,
    output logic [PTE_W-1:0]   mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [PTE_W-1:0]   mem_rsp_rdata,
    input  logic               mem_rsp_fault,
    output logic               rsp_valid,
    output logic               rsp_ok,
    output logic [CAUSE_W-1:0] rsp_cause,
    output logic [PA_W-1:0]    rsp_paddr
);

    state_e             state_q, state_n;
    logic [VA_W-1:0]    va_q;
    acc_e               acc_q, acc_in;
    logic               priv_q, sum_q, mxr_q, aden_q;
    logic [PPN_W-1:0]   base_q;
    logic               lvl_q;
    logic [PTE_W-1:0]   pte_q, upd_q;
    logic               ok_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [PA_W-1:0]    pa_q;

    logic [PTE_W-1:0]   pte_src, pte_upd;
    eval_e              verdict;
    logic [PA_W-1:0]    pte_addr, leaf_pa;

    logic               fin, fin_ok, fin_page, go_down;

    assign acc_in  = (req_acc == 2'd1) ? ACC_STORE : (req_acc == 2'd2) ? ACC_FETCH : ACC_LOAD;
    assign pte_src = (state_q == ST_CAS_WAIT) ? pte_q : mem_rsp_rdata;

    pgwalk_pte_eval u_eval (
        .pte     (pte_src),
        .lvl_top (lvl_q),
        .acc     (acc_q),
        .priv_s  (priv_q),
        .sum     (sum_q),
        .mxr     (mxr_q),
        .verdict (verdict),
        .pte_upd (pte_upd)
    );

    pgwalk_addr u_addr (
        .base_ppn (base_q),
        .lvl_top  (lvl_q),
        .vaddr    (va_q),
        .leaf     (pte_src),
        .pte_addr (pte_addr),
        .paddr    (leaf_pa)
    );

    // next-state and completion decode
    always_comb begin
        state_n  = state_q;
        fin      = 1'b0;
        fin_ok   = 1'b0;
        fin_page = 1'b0;
        go_down  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_n = ST_RD_ISSUE;
            end
            ST_RD_ISSUE: state_n = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_fault) begin
                        fin = 1'b1;
                    end else begin
                        unique case (verdict)
                            EV_DESCEND: begin
                                go_down = 1'b1;
                                state_n = ST_RD_ISSUE;
                            end
                            EV_LEAF_OK: begin
                                fin    = 1'b1;
                                fin_ok = 1'b1;
                            end
                            EV_NEED_AD: begin
                                if (aden_q) begin
                                    state_n = ST_CAS_ISSUE;
                                end else begin
                                    fin      = 1'b1;
                                    fin_page = 1'b1;
                                end
                            end
                            default: begin
                                fin      = 1'b1;
                                fin_page = 1'b1;
                            end
                        endcase
                    end
                end
            end
            ST_CAS_ISSUE: state_n = ST_CAS_WAIT;
            ST_CAS_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_fault) begin
                        fin = 1'b1;
                    end else if (mem_rsp_rdata != pte_q) begin
                        state_n = ST_RD_ISSUE;
                    end else begin
                        fin    = 1'b1;
                        fin_ok = 1'b1;
                    end
                end
            end
            ST_DONE: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
        if (fin) state_n = ST_DONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            acc_q   <= ACC_LOAD;
            priv_q  <= 1'b0;
            sum_q   <= 1'b0;
            mxr_q   <= 1'b0;
            aden_q  <= 1'b0;
            base_q  <= '0;
            lvl_q   <= 1'b1;
            pte_q   <= '0;
            upd_q   <= '0;
            ok_q    <= 1'b0;
            cause_q <= '0;
            pa_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                va_q   <= req_vaddr;
                acc_q  <= acc_in;
                priv_q <= req_priv_s;
                sum_q  <= req_sum;
                mxr_q  <= req_mxr;
                aden_q <= ad_update_en;
                base_q <= root_ppn;
                lvl_q  <= 1'b1;
            end
            if (state_q == ST_RD_WAIT && mem_rsp_valid) begin
                pte_q <= mem_rsp_rdata;
                upd_q <= pte_upd;
            end
            if (go_down) begin
                base_q <= mem_rsp_rdata[FLAG_W +: PPN_W];
                lvl_q  <= 1'b0;
            end
            if (fin) begin
                ok_q    <= fin_ok;
                cause_q <= fin_ok ? '0 : fault_cause(acc_q, fin_page);
                pa_q    <= fin_ok ? leaf_pa : '0;
            end
        end
    end

    // outputs from state
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_RD_ISSUE) || (state_q == ST_CAS_ISSUE);
        mem_req_cas   = (state_q == ST_CAS_ISSUE);
        mem_req_addr  = pte_addr;
        mem_req_cmp   = pte_q;
        mem_req_wdata = upd_q;
        rsp_valid     = (state_q == ST_DONE);
        rsp_ok        = ok_q;
        rsp_cause     = cause_q;
        rsp_paddr     = pa_q;
    end

    // accepted request holds off further requests (R1)
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // result is a single-cycle pulse followed by idle (R1)
    p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

    // memory request lasts one cycle (R2)
    p_mem_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // first read after acceptance targets the root table (R2)
    p_root_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && $past(req_ready) && $past(req_valid) |->
            mem_req_addr[PA_W-1:OFF_W] == $past(root_ppn));

    // fault results carry a nonzero cause (R3)
    p_fault_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ok |-> rsp_cause != '0);

    // compare-and-write only adds A/D flags to the compared entry (R10)
    p_cas_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_cas |->
            mem_req_wdata[B_A] &&
            ((mem_req_wdata & ~(32'h1 << B_A) & ~(32'h1 << B_D)) ==
             (mem_req_cmp   & ~(32'h1 << B_A) & ~(32'h1 << B_D))));

    // page offset passes through on success (R12)
    p_offset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ok |-> rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);

endmodule

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_priv_s = 1'b0;
    logic        req_sum = 1'b0;
    logic        req_mxr = 1'b0;
    logic        ad_update_en = 1'b0;
    logic [21:0] root_ppn = 22'd1;
    logic        mem_req_valid, mem_req_cas;
    logic [33:0] mem_req_addr;
    logic [31:0] mem_req_cmp, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        mem_rsp_fault = 1'b0;
    logic        rsp_valid, rsp_ok;
    logic [3:0]  rsp_cause;
    logic [33:0] rsp_paddr;

    always #4 clk = ~clk;

    pgwalk_top i_pgwalk_top (
        .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_acc,
        .req_priv_s, .req_sum, .req_mxr, .ad_update_en, .root_ppn,
        .mem_req_valid, .mem_req_cas, .mem_req_addr, .mem_req_cmp,
        .mem_req_wdata, .mem_rsp_valid, .mem_rsp_rdata, .mem_rsp_fault,
        .rsp_valid, .rsp_ok, .rsp_cause, .rsp_paddr
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // memory model
    logic [31:0] mem [0:4095];
    logic [33:0] log_addr [0:15];
    int          nlog = 0;
    int          nwrites = 0;
    logic [33:0] fault_rd = '1;
    logic [33:0] fault_wr = '1;
    bit          disturb = 1'b0;
    bit          pend = 1'b0;
    logic [31:0] pend_data;
    logic        pend_fault;

    always @(negedge clk) begin
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = pend_data;
            mem_rsp_fault = pend_fault;
            pend = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_fault = 1'b0;
        end
        if (mem_req_valid) begin
            automatic logic [11:0] idx = mem_req_addr[13:2];
            automatic bit inr = (mem_req_addr[33:14] == '0);
            if (nlog < 16) log_addr[nlog] = mem_req_addr;
            nlog++;
            pend = 1'b1;
            if (!mem_req_cas) begin
                pend_fault = !inr || (mem_req_addr == fault_rd);
                pend_data  = inr ? mem[idx] : '0;
            end else begin
                pend_fault = !inr || (mem_req_addr == fault_wr);
                if (inr && disturb) begin
                    mem[idx] = mem[idx] ^ 32'h100;
                    disturb = 1'b0;
                end
                pend_data = inr ? mem[idx] : '0;
                if (!pend_fault && pend_data == mem_req_cmp) begin
                    mem[idx] = mem_req_wdata;
                    nwrites++;
                end
            end
        end
    end

    function automatic logic [31:0] pte(input logic [21:0] ppn, input logic [7:0] fl);
        return {ppn, 2'b00, fl};
    endfunction

    localparam logic [7:0] V = 8'h01, R = 8'h02, W = 8'h04, X = 8'h08,
                           U = 8'h10, A = 8'h40, D = 8'h80;

    task automatic chk(input bit good, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!good) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] acc,
                        input bit ps, input bit sum, input bit mxr, input bit aden,
                        input bit exp_ok, input logic [3:0] exp_cause,
                        input logic [33:0] exp_pa, input int exp_n, input string req);
        int n;
        nlog = 0;
        @(negedge clk);
        req_vaddr = va; req_acc = acc; req_priv_s = ps; req_sum = sum;
        req_mxr = mxr; ad_update_en = aden; req_valid = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R1", "ready while busy", req_ready, 0);
        while (!rsp_valid && n < 40) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk(rsp_ok == exp_ok, req, "ok", rsp_ok, exp_ok);
        chk(rsp_cause == exp_cause, req, "cause", rsp_cause, exp_cause);
        if (exp_ok) chk(rsp_paddr == exp_pa, req, "paddr", rsp_paddr, exp_pa);
        chk(n == 2 * exp_n + 1, "R2", "latency", n, 2 * exp_n + 1);
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R1", "idle after pulse", {req_ready, rsp_valid}, 2'b10);
    endtask

    task automatic t_reset;
        chk(req_ready && !rsp_valid && !mem_req_valid, "R1", "reset state",
            {req_ready, rsp_valid, mem_req_valid}, 3'b100);
    endtask

    task automatic t_two_level;
        mem[1024 + 3] = pte(22'd2, V);
        mem[2048 + 5] = pte(22'h12345, V | R | A | D);
        walk({10'd3, 10'd5, 12'hABC}, 2'd0, 1, 0, 0, 0, 1, 0, {22'h12345, 12'hABC}, 2, "R12");
        chk(log_addr[0] == 34'h100C, "R2", "root read addr", log_addr[0], 34'h100C);
        chk(log_addr[1] == 34'h2014, "R2", "leaf read addr", log_addr[1], 34'h2014);
    endtask

    task automatic t_superpage;
        mem[1024 + 7] = pte({12'hABC, 10'h0}, V | X | U | A);
        walk({10'd7, 10'h155, 12'h321}, 2'd2, 0, 0, 0, 0, 1, 0,
             {12'hABC, 10'h155, 12'h321}, 1, "R12");
    endtask

    task automatic t_misaligned;
        mem[1024 + 8] = pte({12'h001, 10'h001}, V | R | A);
        walk({10'd8, 22'h0}, 2'd0, 1, 0, 0, 0, 0, 4'd13, 0, 1, "R8");
    endtask

    task automatic t_access_fault;
        fault_rd = 34'h1024;
        walk({10'd9, 22'h0}, 2'd1, 1, 0, 0, 0, 0, 4'd7, 0, 1, "R3");
        walk({10'd9, 22'h0}, 2'd2, 1, 0, 0, 0, 0, 4'd1, 0, 1, "R3");
        walk({10'd9, 22'h0}, 2'd0, 1, 0, 0, 0, 0, 4'd5, 0, 1, "R3");
        fault_rd = '1;
    endtask

    task automatic t_invalid;
        mem[1024 + 10] = 32'h0;
        walk({10'd10, 22'h0}, 2'd0, 1, 0, 0, 0, 0, 4'd13, 0, 1, "R4");
        mem[1024 + 11] = pte(22'd5, V | W);
        walk({10'd11, 22'h0}, 2'd1, 1, 0, 0, 0, 0, 4'd15, 0, 1, "R4");
    endtask

    task automatic t_pointer_bottom;
        mem[1024 + 12] = pte(22'd2, V);
        mem[2048 + 6]  = pte(22'd9, V);
        walk({10'd12, 10'd6, 12'h0}, 2'd0, 1, 0, 0, 0, 0, 4'd13, 0, 2, "R5");
    endtask

    task automatic t_perms;
        mem[1024 + 13] = pte({12'h3, 10'h0}, V | X | A);
        walk({10'd13, 10'h2, 12'h5}, 2'd0, 1, 0, 0, 0, 0, 4'd13, 0, 1, "R6");
        walk({10'd13, 10'h2, 12'h5}, 2'd0, 1, 0, 1, 0, 1, 0, {12'h3, 10'h2, 12'h5}, 1, "R6");
        mem[1024 + 14] = pte({12'h4, 10'h0}, V | R | A);
        walk({10'd14, 22'h0}, 2'd1, 1, 0, 0, 0, 0, 4'd15, 0, 1, "R6");
        walk({10'd14, 22'h0}, 2'd2, 1, 0, 0, 0, 0, 4'd12, 0, 1, "R6");
    endtask

    task automatic t_priv;
        walk({10'd14, 22'h0}, 2'd0, 0, 0, 0, 0, 0, 4'd13, 0, 1, "R7");
        mem[1024 + 15] = pte({12'h5, 10'h0}, V | R | U | A);
        walk({10'd15, 22'h0}, 2'd0, 1, 0, 0, 0, 0, 4'd13, 0, 1, "R7");
        walk({10'd15, 22'h10}, 2'd0, 1, 1, 0, 0, 1, 0, {12'h5, 22'h10}, 1, "R7");
        walk({10'd7, 22'h0}, 2'd2, 1, 1, 0, 0, 0, 4'd12, 0, 1, "R7");
    endtask

    task automatic t_ad_fault;
        nwrites = 0;
        mem[1024 + 16] = pte({12'h6, 10'h0}, V | R | W);
        walk({10'd16, 22'h0}, 2'd0, 1, 0, 0, 0, 0, 4'd13, 0, 1, "R9");
        mem[1024 + 17] = pte({12'h7, 10'h0}, V | R | W | A);
        walk({10'd17, 22'h0}, 2'd1, 1, 0, 0, 0, 0, 4'd15, 0, 1, "R9");
        chk(nwrites == 0, "R9", "no write", nwrites, 0);
        walk({10'd17, 22'h0}, 2'd0, 1, 0, 0, 0, 1, 0, {12'h7, 22'h0}, 1, "R9");
    endtask

    task automatic t_ad_update;
        walk({10'd16, 22'h0}, 2'd0, 1, 0, 0, 1, 1, 0, {12'h6, 22'h0}, 2, "R10");
        chk(mem[1024 + 16] == pte({12'h6, 10'h0}, V | R | W | A), "R10", "A set",
            mem[1024 + 16], pte({12'h6, 10'h0}, V | R | W | A));
        walk({10'd17, 22'h0}, 2'd1, 1, 0, 0, 1, 1, 0, {12'h7, 22'h0}, 2, "R10");
        chk(mem[1024 + 17] == pte({12'h7, 10'h0}, V | R | W | A | D), "R10", "D set",
            mem[1024 + 17], pte({12'h7, 10'h0}, V | R | W | A | D));
    endtask

    task automatic t_cas_retry;
        mem[1024 + 18] = pte({12'h8, 10'h0}, V | R | W);
        disturb = 1'b1;
        walk({10'd18, 22'h0}, 2'd1, 1, 0, 0, 1, 1, 0, {12'h8, 22'h0}, 4, "R11");
        chk(log_addr[2] == log_addr[0], "R11", "re-read addr", log_addr[2], log_addr[0]);
        chk(mem[1024 + 18] == (pte({12'h8, 10'h0}, V | R | W | A | D) | 32'h100), "R11",
            "final entry", mem[1024 + 18], pte({12'h8, 10'h0}, V | R | W | A | D) | 32'h100);
        mem[1024 + 19] = pte({12'h9, 10'h0}, V | R | W);
        fault_wr = 34'h1000 + 34'd19 * 4;
        walk({10'd19, 22'h0}, 2'd1, 1, 0, 0, 1, 0, 4'd7, 0, 2, "R11");
        fault_wr = '1;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_two_level();
        t_superpage();
        t_misaligned();
        t_access_fault();
        t_invalid();
        t_pointer_bottom();
        t_perms();
        t_priv();
        t_ad_fault();
        t_ad_update();
        t_cas_retry();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule